// File: doc/BRIEF.md
# Predicated Widening Outer-Product Subtract Tile

This block keeps four square tiles of single-precision accumulators and, on command, subtracts a two-term outer product from one of them. A command carries two 128-bit source vectors of half-precision values and one mask bit for every 16-bit source element. Each 32-bit lane of the row source holds the two half-precision values that feed one tile row. Each 32-bit lane of the column source holds the two values that feed one tile column.

For every cell the block forms the products row-element-0 × column-element-0 and row-element-1 × column-element-1 in single precision and subtracts both from the cell. Masked-off elements count as +0.0. A cell with no pair of matching active elements keeps its value. The block visits one cell per clock over sixteen clocks, reading the old tile throughout, and then commits the whole new tile in a single clock.

The command input is a valid/ready port. `cmd_ready` is high only while no command is in flight. A command offered while busy stays pending: the source holds `cmd_valid` and all command fields steady until it sees `cmd_ready` high at a clock edge. `done` is a plain one-clock pulse. A host write port loads cells and an asynchronous read port observes them.

Top module: `outer_sub_tile`

## Requirements
- R1: `cmd_ready` is 1 when no command is in flight. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` stays 0 until the command completes, and a command offered meanwhile waits.
- R2: `done` is high for exactly one cycle, in the 16th cycle after the accepting edge. `cmd_ready` returns to 1 in that same cycle.
- R3: Tile row r uses row-source halves 2r (bits 32r+15..32r) and 2r+1 (bits 32r+31..32r+16). Column c uses column-source halves 2c and 2c+1 at the same bit positions. Cell (r,c) sits at linear index 4r+c of the tile chosen by `cmd_tile`.
- R4: Mask bit i belongs to source half i. A half whose mask bit is 0 is used as +0.0, whatever its contents.
- R5: A cell changes only when (row half 0 and column half 0 are both active) or (row half 1 and column half 1 are both active). Otherwise it keeps its previous value, including when all mask bits are 0 or only crossed halves are active.
- R6: A written cell becomes round(round(old − a0·b0) − a1·b1). The products are exact after widening, and each rounding is to nearest-even in single precision.
- R7: Subnormal half-precision inputs, subnormal single-precision old values and subnormal results are all taken as zero.
- R8: Any NaN operand, infinity − infinity and infinity × 0 each give 0x7FC00000.
- R9: Widening is exact for normal values and infinities. An infinite active row half times a nonzero column half gives an infinity of the matching sign.
- R10: While a command runs, every tile reads back its old contents. The new tile appears in full in the `done` cycle, and the other tiles are untouched.
- R11: After reset `cmd_ready` is 1, `done` is 0 and every tile cell reads 0.
- R12: `wr_en` writes `wr_data` to cell `wr_idx` of tile `wr_tile` on the clock edge. `rd_data` shows cell `rd_idx` of tile `rd_tile` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_tile | input | 2 | Target tile |
| cmd_row_vec | input | 128 | Row source halves |
| cmd_row_mask | input | 8 | Active bit per row-source half |
| cmd_col_vec | input | 128 | Column source halves |
| cmd_col_mask | input | 8 | Active bit per column-source half |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | Host cell write |
| wr_tile | input | 2 | Host write tile |
| wr_idx | input | 4 | Host write cell index |
| wr_data | input | 32 | Host write value |
| rd_tile | input | 2 | Read tile |
| rd_idx | input | 4 | Read cell index |
| rd_data | output | 32 | Read value |

## Verification
On every cycle the assertions check the handshake: that `cmd_ready` falls after an accept and is high with `done`, that `done` is a single pulse exactly sixteen cycles after the accept, and that a watched cell does not move before the commit unless the host writes it. The arithmetic is covered only by the bench's scenarios, which compare every tile cell with an independent model: the subtraction and its rounding, the lane layout, inactive elements as +0.0, cells left alone under all-inactive and crossed masks, and NaN, infinity and subnormal handling.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam logic [31:0] QNAN_F32 = 32'h7FC0_0000;
  localparam int F32_SIG_EXT = 27;  // hidden + 23 fraction + 3 guard bits
endpackage

// File: rtl/ost_half_mul.sv
// Exact product of two half-precision operands, delivered as single precision.
// An 11x11-bit significand product fits 24 bits, and the exponent range of two
// halves stays normal in single precision, so no rounding is needed.
module ost_half_mul
  import ost_pkg::*;
(
  input  logic [15:0] x,
  input  logic [15:0] y,
  output logic [31:0] p
);
  logic        zx, zy, ix, iy, nx, ny, s;
  logic [21:0] pr;
  int          e;

  always_comb begin
    zx = (x[14:10] == 5'd0);
    zy = (y[14:10] == 5'd0);
    ix = (x[14:10] == 5'h1F) && (x[9:0] == 10'd0);
    iy = (y[14:10] == 5'h1F) && (y[9:0] == 10'd0);
    nx = (x[14:10] == 5'h1F) && (x[9:0] != 10'd0);
    ny = (y[14:10] == 5'h1F) && (y[9:0] != 10'd0);
    s  = x[15] ^ y[15];
    pr = {1'b1, x[9:0]} * {1'b1, y[9:0]};
    e  = int'(x[14:10]) + int'(y[14:10]) + 97;
    if (nx || ny || (ix && zy) || (iy && zx)) begin
      p = QNAN_F32;
    end else if (ix || iy) begin
      p = {s, 8'hFF, 23'd0};
    end else if (zx || zy) begin
      p = {s, 31'd0};
    end else if (pr[21]) begin
      p = {s, 8'(e + 1), pr[20:0], 2'b00};
    end else begin
      p = {s, 8'(e), pr[19:0], 3'b000};
    end
  end
endmodule

// File: rtl/ost_f32_add.sv
// Single-precision add, round to nearest-even, subnormals flushed to zero.
module ost_f32_add
  import ost_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] y
);
  localparam int W = F32_SIG_EXT;

  logic         za, zb, ia, ib, na, nb, s, up, found;
  logic [31:0]  big, sml;
  logic [W-1:0] sig_b, sig_s, al, s27;
  logic [W:0]   sum28;
  logic [24:0]  m25;
  logic [22:0]  mant;
  int           ex, d, sh;

  always_comb begin
    y = QNAN_F32; big = '0; sml = '0; sig_b = '0; sig_s = '0; al = '0;
    s27 = '0; sum28 = '0; m25 = '0; mant = '0; up = 1'b0; found = 1'b0;
    s = 1'b0; ex = 0; d = 0; sh = 0;
    za = (a[30:23] == 8'd0);
    zb = (b[30:23] == 8'd0);
    ia = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    ib = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    na = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    if (na || nb || (ia && ib && (a[31] != b[31]))) begin
      y = QNAN_F32;
    end else if (ia) begin
      y = a;
    end else if (ib) begin
      y = b;
    end else if (za && zb) begin
      y = {a[31] & b[31], 31'd0};
    end else if (za) begin
      y = b;
    end else if (zb) begin
      y = a;
    end else begin
      if (b[30:0] > a[30:0]) begin
        big = b; sml = a;
      end else begin
        big = a; sml = b;
      end
      s     = big[31];
      ex    = int'(big[30:23]);
      d     = int'(big[30:23]) - int'(sml[30:23]);
      sig_b = {1'b1, big[22:0], 3'b000};
      sig_s = {1'b1, sml[22:0], 3'b000};
      if (d >= W) begin
        al = W'(1);
      end else begin
        al = sig_s >> d;
        if ((sig_s & ((W'(1) << d) - W'(1))) != '0) al[0] = 1'b1;
      end
      if (big[31] == sml[31]) begin
        sum28 = {1'b0, sig_b} + {1'b0, al};
        if (sum28[W]) begin
          s27 = sum28[W:1];
          s27[0] = sum28[1] | sum28[0];
          ex = ex + 1;
        end else begin
          s27 = sum28[W-1:0];
        end
      end else begin
        s27 = sig_b - al;
        for (int i = W - 1; i >= 0; i--) begin
          if (!found && s27[i]) begin
            found = 1'b1;
            sh = W - 1 - i;
          end
        end
        s27 = s27 << sh;
        ex  = ex - sh;
      end
      up   = s27[2] & (s27[3] | s27[1] | s27[0]);
      m25  = {1'b0, s27[W-1:3]} + 25'(up);
      mant = m25[24] ? m25[23:1] : m25[22:0];
      if (m25[24]) ex = ex + 1;
      if (s27 == '0)     y = 32'd0;
      else if (ex >= 255) y = {s, 8'hFF, 23'd0};
      else if (ex <= 0)   y = {s, 31'd0};
      else                y = {s, 8'(ex), mant};
    end
  end
endmodule

// File: rtl/ost_cell_unit.sv
// One tile cell: mask, negate the row halves, two exact products, two rounded adds.
module ost_cell_unit (
  input  logic [31:0] row_pair,
  input  logic [31:0] col_pair,
  input  logic [1:0]  row_act,
  input  logic [1:0]  col_act,
  input  logic [31:0] old_val,
  output logic [31:0] new_val,
  output logic        upd
);
  logic [31:0] prod [2];
  logic [31:0] s1, s2;

  for (genvar k = 0; k < 2; k++) begin : g_term
    logic [15:0] rh, ch;
    assign rh = row_act[k] ? {~row_pair[16*k+15], row_pair[16*k +: 15]} : 16'h0000;
    assign ch = col_act[k] ? col_pair[16*k +: 16] : 16'h0000;
    ost_half_mul u_mul (.x(rh), .y(ch), .p(prod[k]));
  end

  ost_f32_add u_add0 (.a(old_val), .b(prod[0]), .y(s1));
  ost_f32_add u_add1 (.a(s1),      .b(prod[1]), .y(s2));

  assign upd     = (row_act[0] & col_act[0]) | (row_act[1] & col_act[1]);
  assign new_val = upd ? s2 : old_val;
endmodule

// File: rtl/outer_sub_tile.sv
module outer_sub_tile #(
  parameter int VLEN   = 128,
  parameter int NTILES = 4,
  localparam int DIM    = VLEN / 32,
  localparam int CELLS  = DIM * DIM,
  localparam int HALVES = VLEN / 16,
  localparam int CW     = $clog2(CELLS),
  localparam int DW     = $clog2(DIM),
  localparam int TW     = $clog2(NTILES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [TW-1:0]     cmd_tile,
  input  logic [VLEN-1:0]   cmd_row_vec,
  input  logic [HALVES-1:0] cmd_row_mask,
  input  logic [VLEN-1:0]   cmd_col_vec,
  input  logic [HALVES-1:0] cmd_col_mask,
  output logic              done,
  input  logic              wr_en,
  input  logic [TW-1:0]     wr_tile,
  input  logic [CW-1:0]     wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [TW-1:0]     rd_tile,
  input  logic [CW-1:0]     rd_idx,
  output logic [31:0]       rd_data
);
  logic [31:0]       tile_q [NTILES][CELLS];
  logic [31:0]       res_q  [CELLS];
  logic              busy_q, done_q;
  logic [CW-1:0]     cnt_q;
  logic [TW-1:0]     tsel_q;
  logic [VLEN-1:0]   rvec_q, cvec_q;
  logic [HALVES-1:0] rmask_q, cmask_q;

  logic [DW-1:0] r_idx, c_idx;
  logic [31:0]   row_pair, col_pair, old_val, new_val;
  logic [1:0]    row_act, col_act;
  logic          upd;

  assign r_idx    = cnt_q[CW-1:DW];
  assign c_idx    = cnt_q[DW-1:0];
  assign row_pair = rvec_q[int'(r_idx)*32 +: 32];
  assign col_pair = cvec_q[int'(c_idx)*32 +: 32];
  assign row_act  = rmask_q[int'(r_idx)*2 +: 2];
  assign col_act  = cmask_q[int'(c_idx)*2 +: 2];
  assign old_val  = tile_q[tsel_q][cnt_q];

  ost_cell_unit u_cell (
    .row_pair(row_pair), .col_pair(col_pair),
    .row_act(row_act),   .col_act(col_act),
    .old_val(old_val),   .new_val(new_val), .upd(upd)
  );

  assign cmd_ready = ~busy_q;
  assign done      = done_q;
  assign rd_data   = tile_q[rd_tile][rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      tsel_q  <= '0;
      rvec_q  <= '0;
      cvec_q  <= '0;
      rmask_q <= '0;
      cmask_q <= '0;
      for (int t = 0; t < NTILES; t++)
        for (int i = 0; i < CELLS; i++) tile_q[t][i] <= '0;
      for (int i = 0; i < CELLS; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_en) tile_q[wr_tile][wr_idx] <= wr_data;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q  <= 1'b1;
          cnt_q   <= '0;
          tsel_q  <= cmd_tile;
          rvec_q  <= cmd_row_vec;
          cvec_q  <= cmd_col_vec;
          rmask_q <= cmd_row_mask;
          cmask_q <= cmd_col_mask;
        end
      end else begin
        res_q[cnt_q] <= new_val;
        cnt_q        <= cnt_q + 1'b1;
        if (cnt_q == CW'(CELLS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          for (int i = 0; i < CELLS; i++)
            tile_q[tsel_q][i] <= (i == CELLS - 1) ? new_val : res_q[i];
        end
      end
    end
  end
endmodule

// File: rtl/outer_sub_tile_chk.sv
module outer_sub_tile_chk #(
  parameter int TW = 2,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          done,
  input logic          wr_en,
  input logic [TW-1:0] rd_tile,
  input logic [CW-1:0] rd_idx,
  input logic [31:0]   rd_data
);
  localparam int LAT = 1 << CW;
  int gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= LAT + 1;
    else if (cmd_valid && cmd_ready) gap <= 0;
    else if (gap <= LAT) gap <= gap + 1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);  // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (gap == LAT));  // R2
  AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);  // R2
  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(wr_en) && $stable(rd_tile) && $stable(rd_idx)) |-> $stable(rd_data));  // R10
endmodule

bind outer_sub_tile outer_sub_tile_chk #(.TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .wr_en(wr_en), .rd_tile(rd_tile), .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/outer_sub_tile_bench.sv
`timescale 1ns/1ps
module outer_sub_tile_bench;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         cmd_valid = 1'b0, cmd_ready, done;
  logic [1:0]   cmd_tile = '0;
  logic [127:0] cmd_row_vec = '0, cmd_col_vec = '0;
  logic [7:0]   cmd_row_mask = '0, cmd_col_mask = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_tile = '0, rd_tile = '0;
  logic [3:0]   wr_idx = '0, rd_idx = '0;
  logic [31:0]  wr_data = '0, rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mt [4][16];
  int   mcnt = 0;
  logic mdone = 1'b0, started = 1'b0;

  always #2 clk = ~clk;

  outer_sub_tile u_outer_sub_tile (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_tile(cmd_tile), .cmd_row_vec(cmd_row_vec), .cmd_row_mask(cmd_row_mask),
    .cmd_col_vec(cmd_col_vec), .cmd_col_mask(cmd_col_mask), .done(done),
    .wr_en(wr_en), .wr_tile(wr_tile), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_tile(rd_tile), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Handshake model, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0; mdone <= 1'b0;
    end else begin
      mdone <= (mcnt == 1);
      if (cmd_valid && mcnt == 0) mcnt <= 16;
      else if (mcnt != 0) mcnt <= mcnt - 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R1 ready", 32'(cmd_ready), 32'(mcnt == 0));
      chk("R2 done", 32'(done), 32'(mdone));
    end
  end

  function automatic real pow2(int n);
    real r = 1.0;
    if (n >= 0) repeat (n) r = r * 2.0;
    else repeat (-n) r = r / 2.0;
    return r;
  endfunction

  function automatic real h2r(logic [15:0] h);
    real v;
    if (h[14:10] == 5'd0) return 0.0;
    v = (1.0 + real'(h[9:0]) / 1024.0) * pow2(int'(h[14:10]) - 15);
    return h[15] ? -v : v;
  endfunction

  function automatic real f2r(logic [31:0] f);
    real v;
    if (f[30:23] == 8'd0) return 0.0;
    v = (1.0 + real'(f[22:0]) / 8388608.0) * pow2(int'(f[30:23]) - 127);
    return f[31] ? -v : v;
  endfunction

  function automatic logic [31:0] r2f(real x);
    real a, m, fr;
    int e = 0;
    longint mi;
    logic s;
    if (x == 0.0) return 32'd0;
    s = (x < 0.0);
    a = s ? -x : x;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0) begin a = a * 2.0; e--; end
    m  = a * 8388608.0;
    mi = longint'($floor(m));
    fr = m - real'(mi);
    if (fr > 0.5 || (fr == 0.5 && mi[0])) mi++;
    if (mi == 64'd16777216) begin mi = 64'd8388608; e++; end
    return {s, 8'(e + 127), mi[22:0]};
  endfunction

  function automatic logic [31:0] exp_cell(logic [31:0] old, logic [31:0] rp, logic [1:0] ra,
                                           logic [31:0] cp, logic [1:0] ca);
    real p0, p1;
    logic [31:0] r1;
    if (!((ra[0] && ca[0]) || (ra[1] && ca[1]))) return old;
    p0 = (ra[0] ? -h2r(rp[15:0])  : 0.0) * (ca[0] ? h2r(cp[15:0])  : 0.0);
    p1 = (ra[1] ? -h2r(rp[31:16]) : 0.0) * (ca[1] ? h2r(cp[31:16]) : 0.0);
    r1 = r2f(f2r(old) + p0);
    return r2f(f2r(r1) + p1);
  endfunction

  function automatic logic [15:0] rand_half();
    return {1'($urandom), 5'(12 + $urandom_range(0, 6)), 10'($urandom)};
  endfunction

  function automatic logic [31:0] rand_f32();
    return {1'($urandom), 8'(123 + $urandom_range(0, 8)), 23'($urandom)};
  endfunction

  function automatic logic [127:0] rand_vec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[16*i +: 16] = rand_half();
    return v;
  endfunction

  task automatic write_cell(int t, int i, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_tile = 2'(t); wr_idx = 4'(i); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    mt[t][i] = v;
  endtask

  task automatic read_chk(string tag, int t, int i, logic [31:0] exp);
    @(negedge clk);
    rd_tile = 2'(t); rd_idx = 4'(i);
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic tile_chk(string tag, int t);
    for (int i = 0; i < 16; i++) read_chk(tag, t, i, mt[t][i]);
  endtask

  task automatic issue(int t, logic [127:0] a, logic [7:0] am, logic [127:0] b,
                       logic [7:0] bm, bit calc);
    if (calc)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          mt[t][4*r+c] = exp_cell(mt[t][4*r+c], a[32*r +: 32], am[2*r +: 2],
                                  b[32*c +: 32], bm[2*c +: 2]);
    @(negedge clk);
    cmd_tile = 2'(t); cmd_row_vec = a; cmd_row_mask = am;
    cmd_col_vec = b; cmd_col_mask = bm; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic special(logic [31:0] old, logic [15:0] ah, logic [15:0] bh,
                         logic [31:0] exp, string tag);
    write_cell(3, 0, old);
    issue(3, {112'd0, ah}, 8'h01, {112'd0, bh}, 8'h01, 1'b0);
    mt[3][0] = exp;
    wait_done();
    tile_chk(tag, 3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual no completion expected completion");
    summary();
  end

  initial begin
    logic [127:0] a, b;
    int t;
    for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) mt[i][j] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1'b1;
    // R11: reset state
    @(negedge clk);
    chk("R11 ready", 32'(cmd_ready), 32'd1);
    chk("R11 done", 32'(done), 32'd0);
    tile_chk("R11", 0);
    tile_chk("R11", 3);
    // R12: host loads every cell
    for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) write_cell(i, j, rand_f32());
    for (int i = 0; i < 4; i++) tile_chk("R12", i);
    // R3/R6: random commands, full and partial masks
    for (int n = 0; n < 30; n++) begin
      t = $urandom_range(0, 3);
      issue(t, rand_vec(), (n % 3 == 0) ? 8'hFF : 8'($urandom),
            rand_vec(), (n % 4 == 0) ? 8'hFF : 8'($urandom), 1'b1);
      wait_done();
      tile_chk("R3/R6", t);
      tile_chk("R10 other tile", (t + 1) % 4);
    end
    // R10: old contents visible mid-command
    begin
      logic [31:0] pre5, pre15;
      pre5 = mt[1][5]; pre15 = mt[1][15];
      issue(1, rand_vec(), 8'hFF, rand_vec(), 8'hFF, 1'b1);
      read_chk("R10 mid", 1, 5, pre5);
      read_chk("R10 mid", 1, 15, pre15);
      wait_done();
      tile_chk("R10 commit", 1);
    end
    // R1: second command offered while busy waits its turn
    issue(2, rand_vec(), 8'hFF, rand_vec(), 8'hFF, 1'b1);
    issue(2, rand_vec(), 8'h3C, rand_vec(), 8'hF0, 1'b1);
    wait_done();
    tile_chk("R1 queued", 2);
    // R5: all-inactive and crossed masks leave the tile alone
    issue(0, rand_vec(), 8'h00, rand_vec(), 8'h00, 1'b1);
    wait_done();
    tile_chk("R5 all inactive", 0);
    issue(0, rand_vec(), 8'h55, rand_vec(), 8'hAA, 1'b1);
    wait_done();
    tile_chk("R5 crossed", 0);
    issue(0, rand_vec(), 8'hFF, rand_vec(), 8'h00, 1'b1);
    wait_done();
    tile_chk("R5 one side", 0);
    // R4: inactive halves hold NaN payloads yet count as +0.0
    a = rand_vec(); b = rand_vec();
    a[16*5 +: 16] = 16'h7E00; b[16*2 +: 16] = 16'h7E00;
    issue(1, a, 8'b0001_0000, b, 8'b1111_1011, 1'b1);
    wait_done();
    tile_chk("R4", 1);
    // R7, R8, R9: special operands on cell 0 of tile 3
    special(32'h3F80_0000, 16'h7C00, 16'h3C00, 32'hFF80_0000, "R9 inf");
    special(32'hBF80_0000, 16'hFC00, 16'hBC00, 32'hFF80_0000, "R9 neg inf");
    special(32'h7F80_0000, 16'h7C00, 16'h3C00, 32'h7FC0_0000, "R8 inf-inf");
    special(32'h3F80_0000, 16'h7E00, 16'h3C00, 32'h7FC0_0000, "R8 nan");
    special(32'h3F80_0000, 16'h7C00, 16'h0000, 32'h7FC0_0000, "R8 inf*0");
    special(32'h0000_0005, 16'h0001, 16'h3C00, 32'h0000_0000, "R7 sub old");
    special(32'h4000_0000, 16'h03FF, 16'h3C00, 32'h4000_0000, "R7 sub in");
    special(32'h0000_0000, 16'h7BFF, 16'h7BFF, r2f(-65504.0 * 65504.0), "R9 max");
    summary();
  end
endmodule